// File: doc/BRIEF.md
# Rotating Arbitration ID Tracker

This block holds the arbitration identifier of one interrupt controller agent on a shared message bus. The bus grants access by rotating priority: each agent carries an identifier, and a higher identifier means a higher priority. The block keeps that 4-bit identifier up to date and shows it to software in a read-only 32-bit word.

The identifier is reloaded whenever the agent's own ID register is written. After every arbitration round the block applies the rotation rule. It takes three inputs for this: a round-done strobe, a flag that says whether this agent won, and the winner's identifier. The winner drops to priority 0. Losers that were below the winner move up by one. Losers above the winner keep their place. The identifiers across all agents therefore stay a permutation.

The serial bus signalling and the arbitration compare are not part of this block.

Top module: `arbid_tracker`

## Requirements
- R1: While reset is active and after it is released, with no other input, the identifier is 0 and the read word is 00000000h.
- R2: When `id_we_i` is high at a rising clock edge, the identifier after that edge equals `id_wdata_i`.
- R3: When `arb_done_i` and `arb_won_i` are high at an edge and no write occurs, the identifier after that edge is 0.
- R4: When `arb_done_i` is high, `arb_won_i` is low, no write occurs, and the current identifier is less than `winner_id_i`, the identifier after the edge is the current identifier plus one.
- R5: When `arb_done_i` is high, `arb_won_i` is low, no write occurs, and the current identifier is greater than or equal to `winner_id_i`, the identifier does not change.
- R6: When `id_we_i` and `arb_done_i` are both high at the same edge, the written value is loaded and the round result is discarded.
- R7: When neither `id_we_i` nor `arb_done_i` is high, the identifier holds. `arb_won_i` and `winner_id_i` have no effect in that case.
- R8: `reg_rdata_o` carries the identifier in bits 27:24. Bits 31:28 and 23:0 read 0. `arb_id_o` equals the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_we_i | input | 1 | Write strobe of the agent ID register |
| id_wdata_i | input | 4 | Agent ID being written |
| arb_done_i | input | 1 | One-cycle strobe marking the end of an arbitration round |
| arb_won_i | input | 1 | This agent won the round |
| winner_id_i | input | 4 | Identifier of the round's winner |
| arb_id_o | output | 4 | Current arbitration identifier |
| reg_rdata_o | output | 32 | Read-only register word |

## Verification
The bench loads every identifier and then runs a round against every winner identifier, once as the winner and once as a loser. This catches a comparison that is off by one at the equal-ID boundary, an increment where the ID should hold, and a winner that does not return to 0. It also fires a write and a round in the same cycle for every pair of values. A design that gave the round priority would show the rotated value instead of the written one. Idle cycles with the won flag and winner ID toggling expose a design that updates without the strobe. Every result is read through the full register word, so a field placed in the wrong bits or a stray set bit shows up.

// File: rtl/arbid_pkg.sv
package arbid_pkg;
  localparam int unsigned ID_W     = 4;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned FIELD_LO = 24;
  localparam int unsigned FIELD_HI = FIELD_LO + ID_W - 1;

  typedef logic [ID_W-1:0]  arb_id_t;
  typedef logic [REG_W-1:0] reg_word_t;

  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_RELOAD = 2'd1,
    UPD_ROUND  = 2'd2
  } upd_sel_e;
endpackage

// File: rtl/arbid_rotate.sv
module arbid_rotate #(
  parameter int unsigned ID_W = 4
) (
  input  logic [ID_W-1:0] cur_id_i,
  input  logic            won_i,
  input  logic [ID_W-1:0] winner_id_i,
  output logic [ID_W-1:0] nxt_id_o
);
  logic below_winner;

  assign below_winner = cur_id_i < winner_id_i;

  always_comb begin
    if (won_i)             nxt_id_o = '0;
    else if (below_winner) nxt_id_o = cur_id_i + ID_W'(1);
    else                   nxt_id_o = cur_id_i;
  end
endmodule

// File: rtl/arbid_regfmt.sv
module arbid_regfmt #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned FIELD_LO = 24
) (
  input  logic [ID_W-1:0]  id_i,
  output logic [REG_W-1:0] word_o
);
  localparam int unsigned FIELD_HI = FIELD_LO + ID_W - 1;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b >= FIELD_LO && b <= FIELD_HI) begin : g_fld
      assign word_o[b] = id_i[b-FIELD_LO];
    end else begin : g_zero
      assign word_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/arbid_tracker.sv
module arbid_tracker
  import arbid_pkg::*;
#(
  parameter int unsigned P_ID_W     = ID_W,
  parameter int unsigned P_REG_W    = REG_W,
  parameter int unsigned P_FIELD_LO = FIELD_LO
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 id_we_i,
  input  logic [P_ID_W-1:0]    id_wdata_i,
  input  logic                 arb_done_i,
  input  logic                 arb_won_i,
  input  logic [P_ID_W-1:0]    winner_id_i,
  output logic [P_ID_W-1:0]    arb_id_o,
  output logic [P_REG_W-1:0]   reg_rdata_o
);
  logic [P_ID_W-1:0] id_q, id_d, rot_id;
  upd_sel_e          sel;

  arbid_rotate #(.ID_W(P_ID_W)) u_rot (
    .cur_id_i    (id_q),
    .won_i       (arb_won_i),
    .winner_id_i (winner_id_i),
    .nxt_id_o    (rot_id)
  );

  // software reload outranks a round finishing in the same cycle
  always_comb begin
    if (id_we_i)         sel = UPD_RELOAD;
    else if (arb_done_i) sel = UPD_ROUND;
    else                 sel = UPD_HOLD;
  end

  always_comb begin
    unique case (sel)
      UPD_RELOAD: id_d = id_wdata_i;
      UPD_ROUND:  id_d = rot_id;
      default:    id_d = id_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= '0;
    else         id_q <= id_d;
  end

  arbid_regfmt #(.ID_W(P_ID_W), .REG_W(P_REG_W), .FIELD_LO(P_FIELD_LO)) u_fmt (
    .id_i   (id_q),
    .word_o (reg_rdata_o)
  );

  assign arb_id_o = id_q;
endmodule

// File: rtl/arbid_tracker_chk.sv
module arbid_tracker_chk #(
  parameter int unsigned P_ID_W     = 4,
  parameter int unsigned P_REG_W    = 32,
  parameter int unsigned P_FIELD_LO = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               id_we_i,
  input logic [P_ID_W-1:0]  id_wdata_i,
  input logic               arb_done_i,
  input logic               arb_won_i,
  input logic [P_ID_W-1:0]  winner_id_i,
  input logic [P_ID_W-1:0]  arb_id_o,
  input logic [P_REG_W-1:0] reg_rdata_o
);
  localparam int unsigned FHI = P_FIELD_LO + P_ID_W - 1;

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_we_i |=> arb_id_o == $past(id_wdata_i));

  p_win_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_done_i && arb_won_i && !id_we_i) |=> arb_id_o == '0);

  p_lose_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_done_i && !arb_won_i && !id_we_i && arb_id_o < winner_id_i)
    |=> arb_id_o == $past(arb_id_o) + P_ID_W'(1));

  p_lose_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_done_i && !arb_won_i && !id_we_i && arb_id_o >= winner_id_i)
    |=> $stable(arb_id_o));

  p_reload_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_we_i && arb_done_i) |=> arb_id_o == $past(id_wdata_i));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_we_i && !arb_done_i) |=> $stable(arb_id_o));

  p_word_fmt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[FHI:P_FIELD_LO] == arb_id_o &&
    $countones(reg_rdata_o) == $countones(arb_id_o));
endmodule

bind arbid_tracker arbid_tracker_chk #(
  .P_ID_W(P_ID_W), .P_REG_W(P_REG_W), .P_FIELD_LO(P_FIELD_LO)
) u_chk (.*);

// File: tb/tb_arbid_tracker.sv
module tb_arbid_tracker;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        id_we_i = 1'b0;
  logic [3:0]  id_wdata_i = '0;
  logic        arb_done_i = 1'b0;
  logic        arb_won_i = 1'b0;
  logic [3:0]  winner_id_i = '0;
  logic [3:0]  arb_id_o;
  logic [31:0] reg_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  arbid_tracker dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [3:0] exp_id);
    logic [31:0] exp_w;
    exp_w = {4'h0, exp_id, 24'h0};
    checks++;
    if (reg_rdata_o !== exp_w || arb_id_o !== exp_id) begin
      errors++;
      $display("FAIL %s: rdata=%08h id=%0h expected rdata=%08h id=%0h",
               req, reg_rdata_o, arb_id_o, exp_w, exp_id);
    end
  endtask

  // drive for one edge starting at a negedge, sample at the following negedge
  task automatic cycle(input logic we, input logic [3:0] wd, input logic dn,
                       input logic wn, input logic [3:0] wid);
    id_we_i = we; id_wdata_i = wd; arb_done_i = dn; arb_won_i = wn; winner_id_i = wid;
    @(negedge clk_i);
    id_we_i = 1'b0; arb_done_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp;
    @(negedge clk_i);
    check("R1 in reset", 4'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", 4'h0);

    // R2 R3 R4 R5 R8: every id against every winner, won and lost
    for (int id = 0; id < 16; id++) begin
      for (int w = 0; w < 16; w++) begin
        for (int wn = 0; wn < 2; wn++) begin
          cycle(1'b1, 4'(id), 1'b0, 1'b0, 4'h0);
          check("R2 reload", 4'(id));
          cycle(1'b0, 4'h0, 1'b1, 1'(wn), 4'(w));
          if (wn == 1)     exp = 4'h0;
          else if (id < w) exp = 4'(id + 1);
          else             exp = 4'(id);
          if (wn == 1)     check("R3 winner to zero", exp);
          else if (id < w) check("R4 loser below winner increments", exp);
          else             check("R5 loser at or above winner holds", exp);
        end
      end
    end

    // R6: write and round together
    for (int id = 0; id < 16; id++) begin
      for (int wd = 0; wd < 16; wd++) begin
        cycle(1'b1, 4'(id), 1'b0, 1'b0, 4'h0);
        cycle(1'b1, 4'(wd), 1'b1, 1'(wd & 1), 4'hF);
        check("R6 reload beats round", 4'(wd));
      end
    end

    // R7: idle with round inputs toggling
    for (int id = 0; id < 16; id++) begin
      cycle(1'b1, 4'(id), 1'b0, 1'b0, 4'h0);
      for (int k = 0; k < 4; k++) begin
        cycle(1'b0, 4'(~id), 1'b0, 1'(k & 1), 4'(k * 5));
        check("R7 idle hold", 4'(id));
      end
    end

    // R4 chain: repeated losses to winner 15 climb to 15 and then stop
    cycle(1'b1, 4'h0, 1'b0, 1'b0, 4'h0);
    for (int k = 1; k < 18; k++) begin
      cycle(1'b0, 4'h0, 1'b1, 1'b0, 4'hF);
      check("R4 R5 climb", (k > 15) ? 4'hF : 4'(k));
    end

    // R1: reset again from a nonzero state
    cycle(1'b1, 4'hA, 1'b0, 1'b0, 4'h0);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 4'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after second reset", 4'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule